// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits between instruction decode and two parallel execution pipes. Each cycle decode offers up to two instructions in program order: slot A is the older one and slot B the younger. The block decides whether the pair can go out together. The older instruction always leaves on pipe 0. The younger one goes to pipe 1 only when the two are independent, when its operation class is one that pipe 1 can execute, and when neither instruction needs both pipes. The block makes this choice from decoded register indices alone, before any operand is read.

When the pair cannot go out together, the younger instruction is captured in an internal slot and `hold_o` is raised. On the next unstalled cycle that captured instruction becomes the older instruction and issues alone on pipe 0. During that cycle `replay_o` is high and the slot A/B inputs are not consumed, so decode keeps its next pair for one more cycle. A stall input stops all issue and keeps any captured instruction.

Top module: `dual_issue_pair`

## Requirements
- R1: After a synchronous active-low reset, with no valid input, `issue0_o`, `issue1_o`, `hold_o` and `replay_o` are all 0.
- R2: When both slots are valid and no rule below forbids pairing, both issue enables are 1. Pipe 0 carries slot A's fields and pipe 1 carries slot B's fields.
- R3: If slot A's destination is nonzero and equals either source of slot B, only pipe 0 issues and `hold_o` is 1.
- R4: If both slots write the same nonzero destination, only pipe 0 issues and `hold_o` is 1.
- R5: Register index 0 never creates a dependency, neither as a read-after-write match nor as a shared destination.
- R6: Pipe 1 accepts only the classes ALU (code 0), SHIFT (1), LOAD (2) and STORE (3). A younger instruction of class BRANCH (4) or MUL (5) cannot pair, but either class may issue as the older instruction.
- R7: Classes DIV (6) and SYS (7) use both pipes. In either slot they prevent pairing, and the older instruction issues alone.
- R8: In the cycle after `hold_o`, `replay_o` is 1 and the captured younger instruction issues alone on pipe 0 with its own fields. The slot inputs of that cycle are ignored. On the following cycle `replay_o` is 0.
- R9: With exactly one slot valid, that instruction issues on pipe 0 alone with no hold. This applies whether the valid slot is A or B.
- R10: While `stall_i` is 1, both issue enables and `hold_o` are 0, and a captured instruction is kept. After the stall it issues as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze issue and keep captured instruction |
| a_valid_i | input | 1 | Older slot valid |
| a_op_i | input | 3 | Older slot operation class |
| a_rd_i | input | REG_W | Older slot destination index |
| a_rs1_i | input | REG_W | Older slot first source index |
| a_rs2_i | input | REG_W | Older slot second source index |
| b_valid_i | input | 1 | Younger slot valid |
| b_op_i | input | 3 | Younger slot operation class |
| b_rd_i | input | REG_W | Younger slot destination index |
| b_rs1_i | input | REG_W | Younger slot first source index |
| b_rs2_i | input | REG_W | Younger slot second source index |
| issue0_o | output | 1 | Pipe 0 issue enable |
| issue1_o | output | 1 | Pipe 1 issue enable |
| hold_o | output | 1 | Younger instruction captured for the next cycle |
| replay_o | output | 1 | Captured instruction occupies the older position; inputs not consumed |
| p0_op_o | output | 3 | Pipe 0 operation class |
| p0_rd_o | output | REG_W | Pipe 0 destination |
| p0_rs1_o | output | REG_W | Pipe 0 first source |
| p0_rs2_o | output | REG_W | Pipe 0 second source |
| p1_op_o | output | 3 | Pipe 1 operation class |
| p1_rd_o | output | REG_W | Pipe 1 destination |
| p1_rs1_o | output | REG_W | Pipe 1 first source |
| p1_rs2_o | output | REG_W | Pipe 1 second source |

## Verification
The hardest state to reach is a captured instruction that survives a stall of several cycles and then issues with its own fields, not with the fields of whatever decode drives meanwhile. The stimulus first forces a hold with a read-after-write pair. It then raises the stall for two cycles while driving a different, fully pairable pair. After the stall drops, it checks that pipe 0 carries the captured fields and that pipe 1 stays idle. Each replay cycle likewise drives a pair that would otherwise pair, to show that the inputs are ignored.

// File: rtl/pair_pkg.sv
// Package: shared operation-class encoding and default capability masks
// for the dual-issue pairing check.
package pair_pkg;

    localparam int OPC_W   = 3;
    localparam int NUM_OPC = 1 << OPC_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_ALU    = 3'd0,
        OPC_SHIFT  = 3'd1,
        OPC_LOAD   = 3'd2,
        OPC_STORE  = 3'd3,
        OPC_BRANCH = 3'd4,
        OPC_MUL    = 3'd5,
        OPC_DIV    = 3'd6,
        OPC_SYS    = 3'd7
    } opc_e;

    // Classes that the second pipe is able to execute.
    localparam logic [NUM_OPC-1:0] P1_CAP_DEFAULT  = 8'b0000_1111;
    // Classes that occupy both pipes.
    localparam logic [NUM_OPC-1:0] DUAL_USE_DEFAULT = 8'b1100_0000;

endpackage

// File: rtl/pair_op_caps.sv
// Module: pair_op_caps
// Looks up the pipe capabilities of one operation class.
// Assumes: one mask bit per class code, indexed by the code.
module pair_op_caps
    import pair_pkg::*;
#(
    parameter logic [NUM_OPC-1:0] P1_MASK   = P1_CAP_DEFAULT,
    parameter logic [NUM_OPC-1:0] DUAL_MASK = DUAL_USE_DEFAULT
) (
    input  opc_e op_i,
    output logic p1_ok_o,
    output logic dual_o
);

    // Mask lookup for the second-pipe capability and the both-pipe use.
    always_comb begin
        p1_ok_o = P1_MASK[op_i];
        dual_o  = DUAL_MASK[op_i];
    end

endmodule

// File: rtl/pair_hazard_cmp.sv
// Module: pair_hazard_cmp
// Compares register indices of the older and younger instruction to find
// read-after-write and write-after-write conflicts.
// Assumes: indices only, no operand values; when ZERO_HARD is set, index 0
// is a constant register and never forms a conflict.
module pair_hazard_cmp #(
    parameter int REG_W     = 5,
    parameter int NSRC      = 2,
    parameter bit ZERO_HARD = 1'b1
) (
    input  logic [REG_W-1:0]      older_rd_i,
    input  logic [REG_W-1:0]      younger_rd_i,
    input  logic [NSRC*REG_W-1:0] younger_src_i,
    output logic                  raw_o,
    output logic                  waw_o
);

    logic              rd_real;
    logic [NSRC-1:0]   src_hit;

    // Decide whether the older destination is a register that can carry data.
    always_comb begin
        rd_real = !ZERO_HARD || (older_rd_i != '0);
    end

    // One comparator for each source of the younger instruction.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_comb begin
            src_hit[s] = rd_real &&
                         (younger_src_i[s*REG_W +: REG_W] == older_rd_i);
        end
    end

    // Reduce the source hits and check for a shared destination.
    always_comb begin
        raw_o = |src_hit;
        waw_o = rd_real && (younger_rd_i == older_rd_i);
    end

endmodule

// File: rtl/pair_slot_sel.sv
// Module: pair_slot_sel
// Chooses which instructions fill the older and younger positions this
// cycle: the captured instruction during a replay, else slot A then slot B,
// with slot B moved up when slot A is empty.
// Assumes: the valid flag is the top bit of each slot vector.
module pair_slot_sel #(
    parameter int SLOT_W = 19
) (
    input  logic              replay_i,
    input  logic [SLOT_W-1:0] held_i,
    input  logic [SLOT_W-1:0] a_i,
    input  logic [SLOT_W-1:0] b_i,
    output logic [SLOT_W-1:0] older_o,
    output logic [SLOT_W-1:0] younger_o
);

    localparam int VLD = SLOT_W - 1;

    // Position selection with replay priority and compaction.
    always_comb begin
        older_o   = '0;
        younger_o = '0;
        if (replay_i) begin
            older_o = held_i;
        end else if (a_i[VLD]) begin
            older_o   = a_i;
            younger_o = b_i;
        end else begin
            older_o = b_i;
        end
    end

endmodule

// File: rtl/dual_issue_pair.sv
// Module: dual_issue_pair (top)
// Decides each cycle whether two decoded instructions can issue together
// on two pipes. The older one always uses pipe 0; the younger one is
// captured and replayed alone when pairing is refused.
// Assumes: decode does not advance while replay_o or stall_i is high.
module dual_issue_pair
    import pair_pkg::*;
#(
    parameter int                 REG_W     = 5,
    parameter logic [NUM_OPC-1:0] P1_MASK   = P1_CAP_DEFAULT,
    parameter logic [NUM_OPC-1:0] DUAL_MASK = DUAL_USE_DEFAULT,
    parameter bit                 ZERO_HARD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic             a_valid_i,
    input  logic [OPC_W-1:0] a_op_i,
    input  logic [REG_W-1:0] a_rd_i,
    input  logic [REG_W-1:0] a_rs1_i,
    input  logic [REG_W-1:0] a_rs2_i,
    input  logic             b_valid_i,
    input  logic [OPC_W-1:0] b_op_i,
    input  logic [REG_W-1:0] b_rd_i,
    input  logic [REG_W-1:0] b_rs1_i,
    input  logic [REG_W-1:0] b_rs2_i,
    output logic             issue0_o,
    output logic             issue1_o,
    output logic             hold_o,
    output logic             replay_o,
    output logic [OPC_W-1:0] p0_op_o,
    output logic [REG_W-1:0] p0_rd_o,
    output logic [REG_W-1:0] p0_rs1_o,
    output logic [REG_W-1:0] p0_rs2_o,
    output logic [OPC_W-1:0] p1_op_o,
    output logic [REG_W-1:0] p1_rd_o,
    output logic [REG_W-1:0] p1_rs1_o,
    output logic [REG_W-1:0] p1_rs2_o
);

    localparam int NSRC = 2;

    typedef struct packed {
        logic             vld;
        opc_e             op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    slot_t a_s, b_s, held_q, older_s, younger_s;
    logic  replay_q;
    logic  old_p1_ok, old_dual, yng_p1_ok, yng_dual;
    logic  raw_w, waw_w;
    logic  both_vld, pair_ok, hold_w;

    // Pack the input slots.
    always_comb begin
        a_s = '{vld: a_valid_i, op: opc_e'(a_op_i), rd: a_rd_i,
                rs1: a_rs1_i, rs2: a_rs2_i};
        b_s = '{vld: b_valid_i, op: opc_e'(b_op_i), rd: b_rd_i,
                rs1: b_rs1_i, rs2: b_rs2_i};
    end

    pair_slot_sel #(.SLOT_W(SLOT_W)) u_sel (
        .replay_i  (replay_q),
        .held_i    (held_q),
        .a_i       (a_s),
        .b_i       (b_s),
        .older_o   (older_s),
        .younger_o (younger_s)
    );

    pair_op_caps #(.P1_MASK(P1_MASK), .DUAL_MASK(DUAL_MASK)) u_caps_old (
        .op_i    (older_s.op),
        .p1_ok_o (old_p1_ok),
        .dual_o  (old_dual)
    );

    pair_op_caps #(.P1_MASK(P1_MASK), .DUAL_MASK(DUAL_MASK)) u_caps_yng (
        .op_i    (younger_s.op),
        .p1_ok_o (yng_p1_ok),
        .dual_o  (yng_dual)
    );

    pair_hazard_cmp #(.REG_W(REG_W), .NSRC(NSRC), .ZERO_HARD(ZERO_HARD)) u_haz (
        .older_rd_i    (older_s.rd),
        .younger_rd_i  (younger_s.rd),
        .younger_src_i ({younger_s.rs2, younger_s.rs1}),
        .raw_o         (raw_w),
        .waw_o         (waw_w)
    );

    // Pairing decision: independent, pipe-1 capable, no both-pipe class.
    always_comb begin
        both_vld = older_s.vld && younger_s.vld;
        pair_ok  = both_vld && yng_p1_ok && !old_dual && !yng_dual &&
                   !raw_w && !waw_w;
        hold_w   = !stall_i && both_vld && !pair_ok;
    end

    // Issue enables and pipe payloads.
    always_comb begin
        issue0_o = !stall_i && older_s.vld;
        issue1_o = !stall_i && pair_ok;
        hold_o   = hold_w;
        replay_o = replay_q;
        p0_op_o  = older_s.op;
        p0_rd_o  = older_s.rd;
        p0_rs1_o = older_s.rs1;
        p0_rs2_o = older_s.rs2;
        p1_op_o  = younger_s.op;
        p1_rd_o  = younger_s.rd;
        p1_rs1_o = younger_s.rs1;
        p1_rs2_o = younger_s.rs2;
    end

    // Capture a refused younger instruction; release it once replayed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= '0;
            replay_q <= 1'b0;
        end else if (!stall_i) begin
            if (hold_w) begin
                held_q   <= younger_s;
                replay_q <= 1'b1;
            end else if (replay_q) begin
                held_q   <= '0;
                replay_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pair_check_sva.sv
// Module: pair_check_sva
// Property checker for dual_issue_pair, attached with bind below.
// Assumes: same parameters as the checked instance.
module pair_check_sva
    import pair_pkg::*;
#(
    parameter int                 REG_W     = 5,
    parameter logic [NUM_OPC-1:0] P1_MASK   = P1_CAP_DEFAULT,
    parameter logic [NUM_OPC-1:0] DUAL_MASK = DUAL_USE_DEFAULT,
    parameter bit                 ZERO_HARD = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_i,
    input logic             issue0_o,
    input logic             issue1_o,
    input logic             hold_o,
    input logic             replay_o,
    input logic [OPC_W-1:0] p0_op_o,
    input logic [REG_W-1:0] p0_rd_o,
    input logic [OPC_W-1:0] p1_op_o,
    input logic [REG_W-1:0] p1_rd_o,
    input logic [REG_W-1:0] p1_rs1_o,
    input logic [REG_W-1:0] p1_rs2_o
);

    logic p0_rd_live;

    // Whether the pipe-0 destination can carry a dependency.
    always_comb begin
        p0_rd_live = !ZERO_HARD || (p0_rd_o != '0);
    end

    AST_P1_WITH_P0: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_o |-> issue0_o);                                          // R2
    AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_o |-> !(p0_rd_live && (p0_rd_o == p1_rs1_o || p0_rd_o == p1_rs2_o))); // R3
    AST_NO_WAW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_o |-> !(p0_rd_live && p0_rd_o == p1_rd_o));               // R4
    AST_P1_CLASS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_o |-> P1_MASK[p1_op_o]);                                  // R6
    AST_DUAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_o |-> !DUAL_MASK[p0_op_o] && !DUAL_MASK[p1_op_o]);        // R7
    AST_HOLD_THEN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> replay_o);                                            // R8
    AST_REPLAY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_o && !stall_i) |-> (issue0_o && !issue1_o && !hold_o));  // R8
    AST_REPLAY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_o && !stall_i) |=> !replay_o);                           // R8
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (!issue0_o && !issue1_o && !hold_o));                // R10
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && replay_o) |=> replay_o);                             // R10

endmodule

bind dual_issue_pair pair_check_sva #(
    .REG_W(REG_W), .P1_MASK(P1_MASK), .DUAL_MASK(DUAL_MASK), .ZERO_HARD(ZERO_HARD)
) u_pair_chk (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .issue0_o(issue0_o), .issue1_o(issue1_o), .hold_o(hold_o), .replay_o(replay_o),
    .p0_op_o(p0_op_o), .p0_rd_o(p0_rd_o),
    .p1_op_o(p1_op_o), .p1_rd_o(p1_rd_o), .p1_rs1_o(p1_rs1_o), .p1_rs2_o(p1_rs2_o)
);

// File: tb/tb_dual_issue_pair.sv
// Directed bench for dual_issue_pair: one task per scenario.
module tb_dual_issue_pair;

    localparam int RW = 5;
    localparam logic [2:0] ALU = 3'd0, SHF = 3'd1, LD = 3'd2, ST = 3'd3,
                           BR = 3'd4, MUL = 3'd5, DIV = 3'd6, SYS = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0;
    logic av = 1'b0, bv = 1'b0;
    logic [2:0] aop = '0, bop = '0;
    logic [RW-1:0] ard = '0, ars1 = '0, ars2 = '0, brd = '0, brs1 = '0, brs2 = '0;
    logic i0, i1, hold, replay;
    logic [2:0] p0op, p1op;
    logic [RW-1:0] p0rd, p0rs1, p0rs2, p1rd, p1rs1, p1rs2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dual_issue_pair #(.REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall),
        .a_valid_i(av), .a_op_i(aop), .a_rd_i(ard), .a_rs1_i(ars1), .a_rs2_i(ars2),
        .b_valid_i(bv), .b_op_i(bop), .b_rd_i(brd), .b_rs1_i(brs1), .b_rs2_i(brs2),
        .issue0_o(i0), .issue1_o(i1), .hold_o(hold), .replay_o(replay),
        .p0_op_o(p0op), .p0_rd_o(p0rd), .p0_rs1_o(p0rs1), .p0_rs2_o(p0rs2),
        .p1_op_o(p1op), .p1_rd_o(p1rd), .p1_rs1_o(p1rs1), .p1_rs2_o(p1rs2)
    );

    task automatic drv_a(input logic v, input logic [2:0] op,
                         input logic [RW-1:0] rd, input logic [RW-1:0] s1, input logic [RW-1:0] s2);
        av = v; aop = op; ard = rd; ars1 = s1; ars2 = s2;
    endtask

    task automatic drv_b(input logic v, input logic [2:0] op,
                         input logic [RW-1:0] rd, input logic [RW-1:0] s1, input logic [RW-1:0] s2);
        bv = v; bop = op; brd = rd; brs1 = s1; brs2 = s2;
    endtask

    task automatic chk(input string req, input logic e0, input logic e1,
                       input logic eh, input logic er);
        n_tests++;
        if ({i0, i1, hold, replay} !== {e0, e1, eh, er}) begin
            n_fail++;
            $display("FAIL %s: issue0/issue1/hold/replay got %b%b%b%b exp %b%b%b%b",
                     req, i0, i1, hold, replay, e0, e1, eh, er);
        end
    endtask

    task automatic chk_pipe(input string req, input int pipe, input logic [2:0] op,
                            input logic [RW-1:0] rd, input logic [RW-1:0] s1, input logic [RW-1:0] s2);
        logic [3*RW+2:0] got;
        n_tests++;
        got = (pipe == 0) ? {p0op, p0rd, p0rs1, p0rs2} : {p1op, p1rd, p1rs1, p1rs2};
        if (got !== {op, rd, s1, s2}) begin
            n_fail++;
            $display("FAIL %s: pipe%0d fields got %h exp %h", req, pipe, got, {op, rd, s1, s2});
        end
    endtask

    // Evaluate at mid-cycle, then advance to the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Replay cycle: inputs carry a pairable pair that must be ignored (R8).
    task automatic do_replay(input string req, input logic [2:0] op,
                             input logic [RW-1:0] rd, input logic [RW-1:0] s1, input logic [RW-1:0] s2);
        drv_a(1, ALU, 5'd20, 5'd21, 5'd22);
        drv_b(1, ALU, 5'd23, 5'd24, 5'd25);
        #1;
        chk({req, " R8 replay"}, 1, 0, 0, 1);
        chk_pipe({req, " R8 replay fields"}, 0, op, rd, s1, s2);
        step();
        drv_a(0, ALU, 0, 0, 0);
        drv_b(0, ALU, 0, 0, 0);
        #1;
        chk({req, " R8 replay done"}, 0, 0, 0, 0);
        step();
    endtask

    // Pair expected to be refused: older on pipe 0, younger held and replayed.
    task automatic expect_hold(input string req);
        logic [2:0] op; logic [RW-1:0] rd, s1, s2;
        op = bop; rd = brd; s1 = brs1; s2 = brs2;
        #1;
        chk(req, 1, 0, 1, 0);
        chk_pipe(req, 0, aop, ard, ars1, ars2);
        step();
        do_replay(req, op, rd, s1, s2);
    endtask

    task automatic t_reset();
        drv_a(0, ALU, 0, 0, 0);
        drv_b(0, ALU, 0, 0, 0);
        #1;
        chk("R1 reset idle", 0, 0, 0, 0);
        step();
    endtask

    task automatic t_pair();
        drv_a(1, ALU, 5'd1, 5'd2, 5'd3);
        drv_b(1, LD, 5'd4, 5'd5, 5'd6);
        #1;
        chk("R2 alu+load", 1, 1, 0, 0);
        chk_pipe("R2 p0", 0, ALU, 5'd1, 5'd2, 5'd3);
        chk_pipe("R2 p1", 1, LD, 5'd4, 5'd5, 5'd6);
        step();
        drv_a(1, MUL, 5'd7, 5'd8, 5'd9);
        drv_b(1, ST, 5'd10, 5'd11, 5'd12);
        #1;
        chk("R2 R6 mul older + store", 1, 1, 0, 0);
        chk_pipe("R2 p1 store", 1, ST, 5'd10, 5'd11, 5'd12);
        step();
        drv_a(1, BR, 5'd0, 5'd13, 5'd14);
        drv_b(1, SHF, 5'd15, 5'd13, 5'd14);
        #1;
        chk("R2 R6 branch older + shift", 1, 1, 0, 0);
        step();
    endtask

    task automatic t_raw();
        drv_a(1, ALU, 5'd3, 5'd1, 5'd2);
        drv_b(1, ALU, 5'd4, 5'd3, 5'd5);
        expect_hold("R3 raw on rs1");
        drv_a(1, LD, 5'd17, 5'd1, 5'd2);
        drv_b(1, ST, 5'd9, 5'd6, 5'd17);
        expect_hold("R3 raw on rs2");
    endtask

    task automatic t_waw();
        drv_a(1, ALU, 5'd9, 5'd1, 5'd2);
        drv_b(1, ALU, 5'd9, 5'd3, 5'd4);
        expect_hold("R4 same dest");
    endtask

    task automatic t_zero();
        drv_a(1, ST, 5'd0, 5'd6, 5'd7);
        drv_b(1, ALU, 5'd0, 5'd0, 5'd0);
        #1;
        chk("R5 index zero ignored", 1, 1, 0, 0);
        step();
    endtask

    task automatic t_subset();
        drv_a(1, ALU, 5'd1, 5'd2, 5'd3);
        drv_b(1, MUL, 5'd4, 5'd5, 5'd6);
        expect_hold("R6 younger mul");
        drv_a(1, ALU, 5'd1, 5'd2, 5'd3);
        drv_b(1, BR, 5'd0, 5'd5, 5'd6);
        expect_hold("R6 younger branch");
    endtask

    task automatic t_dual();
        drv_a(1, DIV, 5'd1, 5'd2, 5'd3);
        drv_b(1, ALU, 5'd4, 5'd5, 5'd6);
        expect_hold("R7 older div");
        drv_a(1, ALU, 5'd1, 5'd2, 5'd3);
        drv_b(1, SYS, 5'd0, 5'd5, 5'd6);
        expect_hold("R7 younger sys");
    endtask

    task automatic t_single();
        drv_a(1, MUL, 5'd8, 5'd9, 5'd10);
        drv_b(0, ALU, 5'd1, 5'd2, 5'd3);
        #1;
        chk("R9 only A", 1, 0, 0, 0);
        chk_pipe("R9 only A fields", 0, MUL, 5'd8, 5'd9, 5'd10);
        step();
        drv_a(0, ALU, 5'd1, 5'd2, 5'd3);
        drv_b(1, LD, 5'd11, 5'd12, 5'd13);
        #1;
        chk("R9 only B", 1, 0, 0, 0);
        chk_pipe("R9 only B on pipe0", 0, LD, 5'd11, 5'd12, 5'd13);
        step();
        drv_b(0, ALU, 0, 0, 0);
        #1;
        chk("R9 none valid", 0, 0, 0, 0);
        step();
    endtask

    task automatic t_stall();
        drv_a(1, ALU, 5'd1, 5'd2, 5'd3);
        drv_b(1, ALU, 5'd4, 5'd5, 5'd6);
        stall = 1;
        #1;
        chk("R10 stall blocks pair", 0, 0, 0, 0);
        step();
        stall = 0;
        drv_a(1, ALU, 5'd7, 5'd1, 5'd2);
        drv_b(1, SHF, 5'd8, 5'd7, 5'd3);
        #1;
        chk("R10 setup hold", 1, 0, 1, 0);
        step();
        stall = 1;
        drv_a(1, ALU, 5'd20, 5'd21, 5'd22);
        drv_b(1, ALU, 5'd23, 5'd24, 5'd25);
        for (int k = 0; k < 2; k++) begin
            #1;
            chk("R10 stalled replay", 0, 0, 0, 1);
            step();
        end
        stall = 0;
        do_replay("R10 after stall", SHF, 5'd8, 5'd7, 5'd3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pair();
        t_raw();
        t_waw();
        t_zero();
        t_subset();
        t_dual();
        t_single();
        t_stall();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule